// File: doc/BRIEF.md
# UART Control, Break and Baud-Rate Block

This block is the register-facing half of a simple UART. A host writes a control word, a baud divisor and an end-of-packet character over a small synchronous register bus. The control word holds interrupt enables, a break bit and a request-to-send bit. The block uses these registers to drive the serial output pin, the inverted request-to-send pin, a baud tick for the shift logic, the end-of-packet character for packet-aware transfers, and one interrupt line.

The baud tick comes from a down-counter that reloads from the divisor, so ticks arrive at the clock rate divided by (divisor + 1). Two build options trim the block. With flow control disabled, the request-to-send bit cannot be set. With the software-changeable baud rate disabled, the divisor register is removed and a fixed divisor is used.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset every control bit is 0, `txd_o` follows `tx_serial_i` (idle 1), `rts_n_o` is 1, `eop_char_o` is 0x00, and the divisor holds `DIV_FIXED`.
- R2: Control sits at offset 0x3. Bits 3..12 are writable and read back. Bits 0..2 and 13..15 always read 0.
- R3: While control bit 9 (break) is 1, `txd_o` is 0 whatever `tx_serial_i` does. The bit stays set until software writes it to 0.
- R4: `rts_n_o` is the inverse of control bit 11 (request to send), and that bit has no effect on `txd_o`.
- R5: With `FLOW_CTRL_EN`=0, bit 11 ignores writes, reads back 0, and `rts_n_o` stays 1.
- R6: `baud_tick_o` is a one-clock pulse that appears once every (divisor + 1) clocks. A divisor of 0 gives a tick on every clock.
- R7: The divisor sits at offset 0x4. A new value written there is used only when the counter next reloads, after the tick in progress.
- R8: With `DIV_SW_EN`=0, writes to offset 0x4 are ignored, reads return `DIV_FIXED`, and the tick period is `DIV_FIXED`+1.
- R9: The end-of-packet character sits at offset 0x5 in bits 7..0, drives `eop_char_o`, and changes only on a write to that offset.
- R10: `irq_o` is the OR of each status flag ANDed with its enable. The `stat_i` bits map to control enable bits as follows: bit 0 (receive overrun) to enable 3, bit 1 (transmit overrun) to enable 4, bit 5 (shifter empty) to enable 5, bit 6 (transmit ready) to enable 6, bit 7 (read ready) to enable 7, bit 8 (CTS change) to enable 10, and bit 9 (end of packet) to enable 12. Enable 8 (exception) covers the OR of `stat_i` bits 0..4, which are the overrun, framing, parity and break-detect errors.
- R11: `rdata_o` is registered. It shows the addressed register one clock after `rd_i`, and shows 0 after a clock with no read or after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| stat_i | input | 10 | Status and error flags from the transmitter and receiver |
| tx_serial_i | input | 1 | Serial data from the transmit shifter |
| txd_o | output | 1 | Serial output pin |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| baud_tick_o | output | 1 | One-clock baud tick |
| eop_char_o | output | EOP_W | End-of-packet character |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a divisor write that lands partway through a countdown. The old count must finish, and the new period must start only after the next tick. The stimulus writes new divisors at several phases of the countdown, including a divisor of 0, and then random divisor writes, while a behavioural counter in the bench predicts every tick. Break is held while the serial input toggles, so that a transfer in progress is shown to be overridden. A second instance, built with both options off, is driven with the same bus traffic to show that the gated bits and the missing divisor register ignore it.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;
  localparam logic [2:0] A_CTRL = 3'h3;
  localparam logic [2:0] A_DIV  = 3'h4;
  localparam logic [2:0] A_EOP  = 3'h5;

  localparam int unsigned CTRL_LO = 3;
  localparam int unsigned CTRL_HI = 12;
  localparam int unsigned B_BRK   = 9;
  localparam int unsigned B_RTS   = 11;

  localparam int unsigned NUM_FLAGS = 10;
  localparam int unsigned NUM_EN    = 8;
  localparam int unsigned NUM_ERR   = 5;
endpackage

// File: rtl/uart_ctrl_csr.sv
module uart_ctrl_csr import uart_ctrl_pkg::*; #(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned EOP_W        = 8,
  parameter bit          FLOW_CTRL_EN = 1'b1,
  parameter bit          DIV_SW_EN    = 1'b1,
  parameter logic [DIV_W-1:0] DIV_FIXED = DIV_W'(15)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [CTRL_HI:CTRL_LO]  ctrl_o,
  output logic [DIV_W-1:0]        div_o,
  output logic [EOP_W-1:0]        eop_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int unsigned CW = CTRL_HI - CTRL_LO + 1;
  localparam logic [CW-1:0] RTS_BIT = CW'(1) << (B_RTS - CTRL_LO);
  localparam logic [CW-1:0] WMASK   = FLOW_CTRL_EN ? '1 : ~RTS_BIT;

  logic sel_ctrl, sel_div, sel_eop;
  assign sel_ctrl = addr_i == ADDR_W'(A_CTRL);
  assign sel_div  = addr_i == ADDR_W'(A_DIV);
  assign sel_eop  = addr_i == ADDR_W'(A_EOP);

  logic [CW-1:0]    ctrl_q;
  logic [EOP_W-1:0] eop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      eop_q  <= '0;
    end else if (wr_i) begin
      if (sel_ctrl) ctrl_q <= wdata_i[CTRL_HI:CTRL_LO] & WMASK;
      if (sel_eop)  eop_q  <= wdata_i[EOP_W-1:0];
    end
  end

  generate
    if (DIV_SW_EN) begin : g_div_reg
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               div_q <= DIV_FIXED;
        else if (wr_i && sel_div)  div_q <= wdata_i[DIV_W-1:0];
      end
      assign div_o = div_q;
    end else begin : g_div_fixed
      assign div_o = DIV_FIXED;
    end
  endgenerate

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (sel_ctrl)     rd_val[CTRL_HI:CTRL_LO] = ctrl_q;
    else if (sel_div) rd_val = DATA_W'(div_o);
    else if (sel_eop) rd_val = DATA_W'(eop_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end

  assign ctrl_o = ctrl_q;
  assign eop_o  = eop_q;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(15)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = cnt_q == '0;

  // reload only at zero, so a new divisor waits for the running period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= DIV_RST;
    else if (tick_o) cnt_q <= div_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask import uart_ctrl_pkg::*; (
  input  logic [NUM_FLAGS-1:0] stat_i,
  input  logic [NUM_EN-1:0]    en_i,
  output logic                 irq_o
);
  // en_i order: roe, toe, tmt, trdy, rrdy, exc, dcts, eop
  logic [NUM_EN-1:0] src;
  logic              exc;

  assign exc = |stat_i[NUM_ERR-1:0];
  assign src = {stat_i[9], stat_i[8], exc, stat_i[7:5], stat_i[1:0]};
  assign irq_o = |(src & en_i);
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs import uart_ctrl_pkg::*; #(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned EOP_W        = 8,
  parameter bit          FLOW_CTRL_EN = 1'b1,
  parameter bit          DIV_SW_EN    = 1'b1,
  parameter logic [DIV_W-1:0] DIV_FIXED = DIV_W'(15)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [9:0]        stat_i,
  input  logic              tx_serial_i,
  output logic              txd_o,
  output logic              rts_n_o,
  output logic              baud_tick_o,
  output logic [EOP_W-1:0]  eop_char_o,
  output logic              irq_o
);
  logic [CTRL_HI:CTRL_LO] ctrl;
  logic [DIV_W-1:0]       div_act;
  logic [NUM_EN-1:0]      irq_en;

  uart_ctrl_csr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .EOP_W(EOP_W),
    .FLOW_CTRL_EN(FLOW_CTRL_EN), .DIV_SW_EN(DIV_SW_EN), .DIV_FIXED(DIV_FIXED)
  ) u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ctrl_o(ctrl), .div_o(div_act),
    .eop_o(eop_char_o), .rdata_o(rdata_o)
  );

  uart_baud_gen #(.DIV_W(DIV_W), .DIV_RST(DIV_FIXED)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_act), .tick_o(baud_tick_o)
  );

  assign irq_en = {ctrl[12], ctrl[10], ctrl[8:3]};

  uart_irq_mask u_irq (.stat_i(stat_i), .en_i(irq_en), .irq_o(irq_o));

  // break overrides the shifter, even mid-character
  assign txd_o   = ctrl[B_BRK] ? 1'b0 : tx_serial_i;
  assign rts_n_o = ~ctrl[B_RTS];
endmodule

// File: rtl/uart_ctrl_chk.sv
module uart_ctrl_chk import uart_ctrl_pkg::*; #(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned EOP_W        = 8,
  parameter bit          FLOW_CTRL_EN = 1'b1,
  parameter bit          DIV_SW_EN    = 1'b1,
  parameter logic [DIV_W-1:0] DIV_FIXED = DIV_W'(15)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbrk_i,
  input logic              wrts_i,
  input logic [9:0]        stat_i,
  input logic              txd_o,
  input logic              rts_n_o,
  input logic              baud_tick_o,
  input logic [EOP_W-1:0]  eop_char_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DIV_W-1:0]  div_act
);
  logic wr_ctrl;
  assign wr_ctrl = wr_i && addr_i == ADDR_W'(A_CTRL);

  p_brk_force_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && wbrk_i |=> !txd_o);

  p_rts_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    FLOW_CTRL_EN && wr_ctrl && wrts_i |=> !rts_n_o);

  p_rts_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FLOW_CTRL_EN |-> rts_n_o);

  p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o && div_act != '0 |=> !baud_tick_o);

  p_div_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !DIV_SW_EN |-> div_act == DIV_FIXED);

  p_eop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(A_EOP)) |=> $stable(eop_char_o));

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i == '0 |-> !irq_o);

  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);
endmodule

bind uart_ctrl_regs uart_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .EOP_W(EOP_W),
  .FLOW_CTRL_EN(FLOW_CTRL_EN), .DIV_SW_EN(DIV_SW_EN), .DIV_FIXED(DIV_FIXED)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wbrk_i(wdata_i[9]), .wrts_i(wdata_i[11]), .stat_i(stat_i), .txd_o(txd_o),
  .rts_n_o(rts_n_o), .baud_tick_o(baud_tick_o), .eop_char_o(eop_char_o),
  .irq_o(irq_o), .rdata_o(rdata_o), .div_act(div_act)
);

// File: tb/tb_uart_ctrl_regs.sv
module tb_uart_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr = 0, rd = 0, ser = 1;
  logic [2:0]  addr = 0;
  logic [15:0] wd = 0;
  logic [9:0]  st = 0;

  logic [15:0] rdata [2];
  logic [7:0]  eop   [2];
  logic        txd [2], rts_n [2], tick [2], irq [2];

  uart_ctrl_regs #(.FLOW_CTRL_EN(1'b1), .DIV_SW_EN(1'b1), .DIV_FIXED(16'd5)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata[0]), .stat_i(st), .tx_serial_i(ser), .txd_o(txd[0]),
    .rts_n_o(rts_n[0]), .baud_tick_o(tick[0]), .eop_char_o(eop[0]), .irq_o(irq[0]));

  uart_ctrl_regs #(.FLOW_CTRL_EN(1'b0), .DIV_SW_EN(1'b0), .DIV_FIXED(16'd3)) dut_fix (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata[1]), .stat_i(st), .tx_serial_i(ser), .txd_o(txd[1]),
    .rts_n_o(rts_n[1]), .baud_tick_o(tick[1]), .eop_char_o(eop[1]), .irq_o(irq[1]));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state per instance
  int m_ctrl [2], m_div [2], m_cnt [2], m_eop [2], m_rd [2];
  int fixed_div [2] = '{5, 3};
  bit flow [2] = '{1, 0};
  bit sw   [2] = '{1, 0};

  function automatic void chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ctrl[i] = 0; m_div[i] = fixed_div[i]; m_cnt[i] = fixed_div[i];
      m_eop[i] = 0; m_rd[i] = 0;
    end
  endfunction

  function automatic bit exp_irq(int c);
    bit e = 0;
    if (st[0] && c[3]) e = 1;
    if (st[1] && c[4]) e = 1;
    if (st[5] && c[5]) e = 1;
    if (st[6] && c[6]) e = 1;
    if (st[7] && c[7]) e = 1;
    if ((st[4:0] != 0) && c[8]) e = 1;
    if (st[8] && c[10]) e = 1;
    if (st[9] && c[12]) e = 1;
    return e;
  endfunction

  function automatic void compare();
    for (int i = 0; i < 2; i++) begin
      chk("R3", "txd", txd[i], m_ctrl[i][9] ? 0 : ser);
      chk(i == 0 ? "R4" : "R5", "rts_n", rts_n[i], m_ctrl[i][11] ? 0 : 1);
      chk(i == 0 ? "R6 R7" : "R6 R8", "tick", tick[i], m_cnt[i] == 0);
      chk("R10", "irq", irq[i], exp_irq(m_ctrl[i]));
      chk("R9", "eop", eop[i], m_eop[i]);
      chk(i == 0 ? "R2 R11" : "R5 R8 R11", "rdata", rdata[i], m_rd[i]);
    end
  endfunction

  function automatic void model_clock();
    for (int i = 0; i < 2; i++) begin
      int rv = 0;
      if (rd) begin
        if (addr == 3) rv = m_ctrl[i];
        else if (addr == 4) rv = m_div[i];
        else if (addr == 5) rv = m_eop[i];
      end
      m_rd[i] = rv;
      m_cnt[i] = (m_cnt[i] == 0) ? m_div[i] : m_cnt[i] - 1;
      if (wr) begin
        if (addr == 3) m_ctrl[i] = wd & (flow[i] ? 16'h1FF8 : 16'h17F8);
        if (addr == 4 && sw[i]) m_div[i] = wd;
        if (addr == 5) m_eop[i] = wd[7:0];
      end
    end
  endfunction

  task automatic step(bit w, bit r, logic [2:0] a, logic [15:0] d, logic [9:0] s, bit sd);
    wr = w; rd = r; addr = a; wd = d; st = s; ser = sd;
    #1;
    compare();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    for (int i = 0; i < 2; i++) begin
      chk("R1", "txd idle", txd[i], 1);
      chk("R1", "rts_n idle", rts_n[i], 1);
      chk("R1", "eop reset", eop[i], 0);
      chk("R1", "irq reset", irq[i], 0);
    end
    step(0, 1, 4, 0, 0, 1);  // R1 divisor reset value
    step(0, 1, 3, 0, 0, 0);  // R1 control reads 0, txd follows serial
    idle(1);

    // R2 writable bits, reserved bits read 0
    step(1, 0, 3, 16'hFFFF, 0, 1);
    step(0, 1, 3, 0, 0, 1);
    step(1, 0, 3, 16'h0000, 0, 1);
    step(0, 1, 3, 0, 0, 1);

    // R3 break held while the shifter toggles, then cleared
    step(1, 0, 3, 16'h0200, 0, 1);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 0, k[0]);
    step(1, 0, 3, 16'h0000, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, k[0]);

    // R4 / R5 request to send
    step(1, 0, 3, 16'h0800, 0, 1);
    step(0, 1, 3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 3, 16'h0000, 0, 1);
    idle(2);

    // R6 R7 R8 divisor writes at several countdown phases
    idle(3);
    step(1, 0, 4, 16'd2, 0, 1);
    idle(10);
    step(1, 0, 4, 16'd0, 0, 1);
    idle(6);
    step(1, 0, 4, 16'd7, 0, 1);
    idle(4);
    step(1, 0, 4, 16'd1, 0, 1);
    idle(20);
    step(0, 1, 4, 0, 0, 1);
    idle(1);

    // R9 end-of-packet character
    step(1, 0, 5, 16'h00A5, 0, 1);
    step(0, 1, 5, 0, 0, 1);
    step(1, 0, 3, 16'h1FF8, 0, 1);
    step(1, 0, 5, 16'h1F3C, 0, 1);
    step(0, 1, 5, 0, 0, 1);
    idle(1);

    // R10 each enable alone against each flag
    for (int b = 3; b <= 12; b++) begin
      if (b == 9 || b == 11) continue;
      step(1, 0, 3, 16'(1 << b), 0, 1);
      for (int f = 0; f < 10; f++) step(0, 0, 0, 0, 10'(1 << f), 1);
    end
    step(1, 0, 3, 16'h0000, 10'h3FF, 1);
    step(0, 0, 0, 0, 10'h3FF, 1);

    // R11 unmapped offsets and the idle read bus
    step(0, 1, 0, 0, 0, 1);
    step(0, 1, 7, 0, 0, 1);
    step(0, 1, 2, 0, 0, 1);
    idle(2);

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a = 3'(3 + ($urandom % 3));
      logic [15:0] d = 16'($urandom);
      if (a == 4) d = 16'($urandom % 9);
      step(($urandom % 3) == 0, ($urandom % 2) == 0, a, d, 10'($urandom), 1'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule